// File: doc/BRIEF.md
# Transmit VLAN Tag Inserter

This block sits on the transmit path of an Ethernet MAC, between the stage that gathers a frame from its buffer segments and the MAC itself. Bytes arrive as a stream with first-byte and last-byte markers. The per-frame control comes from the descriptor: an insert request and a 16-bit tag control value. The block stores the whole frame. Once the last byte is in, it decides whether to add an 802.1Q tag, and then replays the frame downstream. Each output byte comes with the outgoing frame length and a lost-packet indication.

Because the decision is taken only after the final segment has arrived, the block always knows the true frame length and the existing EtherType before it emits anything. Frames that are already tagged pass through untouched. Frames too short to hold the two MAC addresses and an EtherType, and frames that would overflow the buffer once tagged, are handled by fixed fallbacks that raise the lost flag. A completion pulse follows every frame that leaves the block.

Top module: `vlan_tag_inserter`

## Requirements
- R1: When a tag is inserted, output bytes 0..11 equal input bytes 0..11. Output bytes 12,13,14,15 are 0x81, 0x00, tag[15:8] and tag[7:0]. Every output byte k at or above 16 equals input byte k-4.
- R2: A tag is inserted only when the insert request is 1 and input bytes 12,13 are not 0x81,0x00. When no tag is inserted, the output is the stored input unchanged, with the same length. If no insert was requested, or if the frame is already tagged, the lost flag is 0.
- R3: The insert request and the tag value are taken on the byte marked as first. Changes to them on later bytes of the same frame have no effect.
- R4: A frame shorter than 14 bytes with the insert request set leaves unchanged, and the lost flag is 1.
- R5: If the stored length plus 4 exceeds CAP, the last 4 stored bytes are dropped, the tag is still inserted, the output length equals the stored length, and the lost flag is 1.
- R6: A successful insertion with no overflow gives an output length equal to the input length plus 4.
- R7: `tx_done` is high for exactly one cycle, in the cycle after the last output byte is accepted. This happens for every frame, whether or not it was tagged.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_data` holds its value. `in_ready` is 0 from the accepted last input byte until the last output byte is accepted.
- R9: Input bytes beyond CAP are discarded, so the stored length is at most CAP.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and `tx_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | Marks the first byte of a frame |
| in_eof | input | 1 | Marks the last byte of a frame |
| in_ins_en | input | 1 | Insert request, sampled with the first byte |
| in_tci | input | 16 | Tag control value, sampled with the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Sink accepts the output byte |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First output byte |
| out_eof | output | 1 | Last output byte |
| out_len | output | $clog2(CAP+1) | Length of the outgoing frame |
| out_lost | output | 1 | Lost-packet indication for this frame |
| tx_done | output | 1 | One-cycle completion pulse per frame |

## Verification
The bench sweeps every input length from 1 to beyond the buffer size. Each length is sent with and without the insert request, and with untagged, tagged and near-tagged (0x81,0x01) EtherType bytes, against random sink stalls. The sweep targets three kinds of fault. A design that compares only the first EtherType byte would leave near-tagged frames untagged. A design with an off-by-one at the 14-byte or CAP-4 boundary would tag a frame that must fall back, or drop the wrong four bytes. A design that re-reads the control inputs after the first byte would pick up the deliberately corrupted values that follow it. Stall cycles also expose a design that changes its output data while the sink is not ready, or that pulses completion only for tagged frames.

// File: rtl/vlan_tag_inserter.sv
module vlan_tag_inserter #(
  parameter int CAP = 64,
  localparam int LW = $clog2(CAP + 1),
  localparam int AW = $clog2(CAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [7:0]    in_data,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic          in_ins_en,
  input  logic [15:0]   in_tci,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_sof,
  output logic          out_eof,
  output logic [LW-1:0] out_len,
  output logic          out_lost,
  output logic          tx_done
);

  typedef enum logic [1:0] {S_FILL, S_DECIDE, S_SEND} st_t;

  st_t           st_q;
  logic [7:0]    mem_q [CAP];
  logic [LW-1:0] cnt_q, oi_q, olen_q;
  logic          en_q, ins_q, lost_q, done_q;
  logic [15:0]   tci_q;

  wire in_fire  = in_valid && in_ready;
  wire out_fire = out_valid && out_ready;
  wire last_out = (oi_q == olen_q - LW'(1));
  wire is_tagged = (mem_q[AW'(12)] == 8'h81) && (mem_q[AW'(13)] == 8'h00);
  wire too_short = (cnt_q < LW'(14));
  wire overflow  = ({1'b0, cnt_q} + (LW+1)'(4)) > (LW+1)'(CAP);
  wire want      = en_q && !(!too_short && is_tagged);

  assign in_ready  = (st_q == S_FILL);
  assign out_valid = (st_q == S_SEND);
  assign out_sof   = (oi_q == '0);
  assign out_eof   = last_out;
  assign out_len   = olen_q;
  assign out_lost  = lost_q;
  assign tx_done   = done_q;

  logic [LW-1:0] rd_idx;
  always_comb begin
    rd_idx   = oi_q;
    out_data = 8'h00;
    if (ins_q && oi_q >= LW'(16)) rd_idx = oi_q - LW'(4);
    if (ins_q && oi_q >= LW'(12) && oi_q < LW'(16)) begin
      case (oi_q[1:0])
        2'd0:    out_data = 8'h81;
        2'd1:    out_data = 8'h00;
        2'd2:    out_data = tci_q[15:8];
        default: out_data = tci_q[7:0];
      endcase
    end else begin
      out_data = mem_q[rd_idx[AW-1:0]];
    end
  end

  always_ff @(posedge clk)
    if (in_fire && cnt_q != LW'(CAP)) mem_q[cnt_q[AW-1:0]] <= in_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_FILL;
      cnt_q  <= '0;
      oi_q   <= '0;
      olen_q <= '0;
      en_q   <= 1'b0;
      tci_q  <= '0;
      ins_q  <= 1'b0;
      lost_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= out_fire && last_out;
      case (st_q)
        S_FILL: if (in_fire) begin
          if (in_sof) begin
            en_q  <= in_ins_en;
            tci_q <= in_tci;
          end
          if (cnt_q != LW'(CAP)) cnt_q <= cnt_q + LW'(1);
          if (in_eof) st_q <= S_DECIDE;
        end
        S_DECIDE: begin
          oi_q <= '0;
          st_q <= S_SEND;
          if (want && too_short) begin
            ins_q <= 1'b0; lost_q <= 1'b1; olen_q <= cnt_q;
          end else if (want && overflow) begin
            ins_q <= 1'b1; lost_q <= 1'b1; olen_q <= cnt_q;
          end else if (want) begin
            ins_q <= 1'b1; lost_q <= 1'b0; olen_q <= cnt_q + LW'(4);
          end else begin
            ins_q <= 1'b0; lost_q <= 1'b0; olen_q <= cnt_q;
          end
        end
        default: if (out_fire) begin
          oi_q <= oi_q + LW'(1);
          if (last_out) begin
            st_q  <= S_FILL;
            cnt_q <= '0;
          end
        end
      endcase
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_len));

  assert_len_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len <= LW'(CAP)) && (out_len != '0));

  assert_lost_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_lost |-> en_q);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(out_valid && out_ready && out_eof));

  assert_grow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof && ins_q && !out_lost |-> out_len >= LW'(18));

  assert_ctrl_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != S_FILL |=> $stable(tci_q) && $stable(en_q));

endmodule

// File: tb/test_vlan_tag_inserter.sv
module test_vlan_tag_inserter;
  localparam int CLK_PERIOD = 10;
  localparam int CAP = 24;
  localparam int LW = $clog2(CAP + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_ins_en = 0, out_ready = 0;
  logic [7:0] in_data = 0;
  logic [15:0] in_tci = 0;
  logic in_ready, out_valid, out_sof, out_eof, out_lost, tx_done;
  logic [7:0] out_data;
  logic [LW-1:0] out_len;

  int checks = 0, fails = 0;
  logic [7:0] lfsr = 8'h5A;
  logic [7:0] src [0:63];
  logic [7:0] expv [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  vlan_tag_inserter #(.CAP(CAP)) i_vlan_tag_inserter (
    .clk, .rst_n, .in_valid, .in_ready, .in_data, .in_sof, .in_eof,
    .in_ins_en, .in_tci, .out_valid, .out_ready, .out_data, .out_sof,
    .out_eof, .out_len, .out_lost, .tx_done);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input int len, input bit en, input int tagmode);
    logic [15:0] tci;
    int eff, keep, olen;
    bit want, ins, lost;
    tci = 16'hA000 + 16'(len * 19 + tagmode * 7);
    for (int i = 0; i < len; i++) src[i] = 8'(i * 37 + len * 5 + 3);
    if (len > 13) begin
      src[12] = (tagmode == 0) ? 8'h08 : 8'h81;
      src[13] = (tagmode == 2) ? 8'h01 : 8'h00;
    end
    eff  = (len > CAP) ? CAP : len;
    want = en && !(eff >= 14 && tagmode == 1);
    ins  = want && eff >= 14;
    lost = want && (eff < 14 || eff + 4 > CAP);
    keep = (ins && eff + 4 > CAP) ? eff - 4 : eff;
    olen = ins ? keep + 4 : keep;
    for (int k = 0; k < olen; k++)
      if (!ins || k < 12) expv[k] = src[k];
      else if (k == 12) expv[k] = 8'h81;
      else if (k == 13) expv[k] = 8'h00;
      else if (k == 14) expv[k] = tci[15:8];
      else if (k == 15) expv[k] = tci[7:0];
      else expv[k] = src[k-4];

    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid  = 1;
      in_data   = src[i];
      in_sof    = (i == 0);
      in_eof    = (i == len - 1);
      in_ins_en = (i == 0) ? en : ~en;
      in_tci    = (i == 0) ? tci : ~tci;
      while (!in_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0;

    begin
      int k = 0;
      bit fin = 0, stalled = 0;
      logic [7:0] held = 0;
      while (!fin) begin
        if (k != 0 || stalled) @(negedge clk);
        if (stalled) check(out_data == held, "R8 hold", out_data, held);
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = lfsr[0] | lfsr[2];
        if (out_valid) begin
          check(!in_ready, "R8 in_ready", in_ready, 0);
          if (out_ready) begin
            check(out_data == expv[k], "R1/R2 data", out_data, expv[k]);
            if (k == 0) begin
              check(out_sof, "R1 sof", out_sof, 1);
              check(out_len == LW'(olen), ins && !lost ? "R6 len" : "R5/R9 len", out_len, olen);
              check(out_lost == lost, eff < 14 ? "R4 lost" : "R5 lost", out_lost, lost);
            end
            if (out_eof) begin
              check(k == olen - 1, "R2 eof position", k, olen - 1);
              fin = 1;
            end
            k++;
            stalled = 0;
          end else begin
            stalled = 1;
            held = out_data;
          end
        end else begin
          stalled = 0;
          if (k == 0) @(negedge clk);
        end
        if (k >= 64) fin = 1;
      end
      @(negedge clk);
      out_ready = 0;
      check(tx_done, "R7 done", tx_done, 1);
      @(negedge clk);
      check(!tx_done, "R7 single pulse", tx_done, 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!out_valid, "R10 out_valid", out_valid, 0);
    check(in_ready, "R10 in_ready", in_ready, 1);
    check(!tx_done, "R10 tx_done", tx_done, 0);
    for (int len = 1; len <= CAP + 3; len++)
      for (int en = 0; en < 2; en++)
        for (int tm = 0; tm < 3; tm++)
          if (len > 13 || tm == 0) run_frame(len, en[0], tm);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule